// File: doc/BRIEF.md
# UART Line Status Tracker

This block holds the eight-bit line status word of a UART that can run either with single-character holding registers ("character mode") or with receive and transmit FIFOs ("FIFO mode"). It does not move data. It watches single-cycle event pulses from the receiver, the transmitter and the FIFO storage. It also watches the level signals that describe FIFO occupancy and shifter state. From these it maintains each status bit under rules that depend on the mode. The CPU reads the word through the register file. A read strobe tells the block when that read happens, so that the read-to-clear bits can be dropped.

In FIFO mode the block counts how many queued receive entries carry a parity, framing or break flag. The error-summary bit stays set while that count is nonzero, even across a status read. The block also drives two interrupt request lines. One is a receive-line-status request gated by its enable. The other is a transmit-empty request that is raised when the holding-empty bit rises and dropped when the interrupt-identification register is read. The priority encoder that ranks these requests is outside this block.

Top module: `uart_line_status`

## Requirements
- R1: With reset asserted (rst_n low), character mode selected, the shifter idle and both FIFOs reported empty, `lsr_q` reads 0x60 and both interrupt lines are low.
- R2: Bit 0 (data ready). In character mode it sets on `rx_done` and clears on `rx_pop`; if both occur in the same cycle, it is set. In FIFO mode it equals the inverse of `rx_fifo_empty`.
- R3: On `rx_done`, bit 2 sets if `rx_par_bad` is high, bit 3 sets if `rx_stop_bad` is high, and bit 4 sets if `rx_brk` is high.
- R4: Bit 1 (overrun). In character mode it sets when `rx_done` arrives while bit 0 is set and there is no `rx_pop` in that cycle. In FIFO mode it sets when `rx_done` arrives while `rx_fifo_full` is high; that character is not counted as queued.
- R5: `lsr_rd` clears bits 1 to 4 on the next clock edge. A set event in the same cycle as the read wins.
- R6: `irq_rls` is high exactly while `rls_ie` is high and any of bits 1 to 4 is set.
- R7: Bit 7 is 0 one cycle after character mode is in effect. In FIFO mode, an errored push makes it 1, and it stays 1 until a status read occurs in a cycle after which no errored entry remains.
- R8: The errored-entry count clears on `rx_fifo_clr` or when FIFO mode is off. It counts flagged pushes into a non-full FIFO and pops with `rx_pop_err` high.
- R9: Bit 5 in character mode clears on `tx_write` and sets on `tx_load`; if both occur in the same cycle, the write wins.
- R10: Bit 5 in FIFO mode is registered as `tx_fifo_empty` and is forced low in any cycle with `tx_write`.
- R11: Bit 6 is 1 only when bit 5 is 1 and `tx_shift_idle` is high.
- R12: `irq_thre` rises in the cycle bit 5 rises and clears on `iir_rd`. A rise in the same cycle as `iir_rd` keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously upstream |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 character mode |
| rls_ie | input | 1 | Receive-line-status interrupt enable |
| rx_done | input | 1 | Pulse: a received character is complete |
| rx_par_bad | input | 1 | Parity flag of the completing character |
| rx_stop_bad | input | 1 | Stop-bit flag of the completing character |
| rx_brk | input | 1 | Break flag of the completing character |
| rx_pop | input | 1 | Pulse: CPU read of the receive holding register or FIFO head |
| rx_pop_err | input | 1 | The entry being popped carries an error flag |
| rx_fifo_full | input | 1 | Receive FIFO full level |
| rx_fifo_empty | input | 1 | Receive FIFO empty level |
| rx_fifo_clr | input | 1 | Pulse: receive FIFO reset |
| tx_load | input | 1 | Pulse: holding register moved into the transmit shifter |
| tx_write | input | 1 | Pulse: CPU write to the holding register or transmit FIFO |
| tx_fifo_empty | input | 1 | Transmit FIFO empty level |
| tx_shift_idle | input | 1 | Transmit shifter holds no character |
| lsr_rd | input | 1 | Pulse: CPU read of the status word |
| iir_rd | input | 1 | Pulse: CPU read of the interrupt identification register |
| lsr_q | output | 8 | Line status word |
| irq_rls | output | 1 | Receive-line-status interrupt request |
| irq_thre | output | 1 | Transmit-empty interrupt request |

## Verification
Two pairs of functions are made to collide. In the first, a status read lands in the same cycle as a new error event: the bench raises `lsr_rd` together with `rx_done` and a framing flag, and expects the old parity bit gone while the new framing bit is present. In the second, an interrupt-identification read lands in the cycle the holding-empty bit rises: `iir_rd` is driven while the transmit FIFO returns to empty, and `irq_thre` must stay high. The bench also reads the status word while an errored entry is still queued in FIFO mode, and expects bit 7 to survive that read.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int LSR_W   = 8;
  localparam int B_DRDY  = 0;
  localparam int B_OVR   = 1;
  localparam int B_PAR   = 2;
  localparam int B_FRM   = 3;
  localparam int B_BRK   = 4;
  localparam int B_THRE  = 5;
  localparam int B_TEMT  = 6;
  localparam int B_RXSUM = 7;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } rx_err_t;
endpackage

// File: rtl/lsr_err_count.sv
module lsr_err_count #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          clr,
  output logic [CW-1:0] cnt_next
);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && !dec && cnt_q != CMAX) begin
      cnt_d = cnt_q + 1'b1;
    end else if (dec && !inc && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_next = cnt_d;
endmodule

// File: rtl/lsr_rx_track.sv
module lsr_rx_track
  import uart_lsr_pkg::*;
#(
  parameter int RX_DEPTH = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fifo_mode,
  input  logic    rx_done,
  input  logic    rx_par_bad,
  input  logic    rx_stop_bad,
  input  logic    rx_brk,
  input  logic    rx_pop,
  input  logic    rx_pop_err,
  input  logic    rx_fifo_full,
  input  logic    rx_fifo_empty,
  input  logic    rx_fifo_clr,
  input  logic    lsr_rd,
  output logic    data_rdy,
  output rx_err_t err,
  output logic    err_sum
);
  localparam int CW = $clog2(RX_DEPTH + 1);

  logic          dr_q, dr_d;
  rx_err_t       err_q, err_d;
  logic          sum_q, sum_d;
  logic [CW-1:0] cnt_next;
  logic          flagged, ovr_evt;

  assign flagged = rx_par_bad | rx_stop_bad | rx_brk;
  assign ovr_evt = rx_done & (fifo_mode ? rx_fifo_full : (dr_q & ~rx_pop));

  lsr_err_count #(.DEPTH(RX_DEPTH)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (fifo_mode & rx_done & flagged & ~rx_fifo_full),
    .dec      (fifo_mode & rx_pop & rx_pop_err),
    .clr      (rx_fifo_clr | ~fifo_mode),
    .cnt_next (cnt_next)
  );

  always_comb begin
    dr_d = dr_q;
    if (fifo_mode)    dr_d = 1'b0;
    else if (rx_done) dr_d = 1'b1;
    else if (rx_pop)  dr_d = 1'b0;

    err_d = lsr_rd ? '0 : err_q;
    if (rx_done) begin
      if (rx_par_bad)  err_d.par = 1'b1;
      if (rx_stop_bad) err_d.frm = 1'b1;
      if (rx_brk)      err_d.brk = 1'b1;
    end
    if (ovr_evt) err_d.ovr = 1'b1;

    sum_d = sum_q;
    if (!fifo_mode)         sum_d = 1'b0;
    else if (cnt_next != 0) sum_d = 1'b1;
    else if (lsr_rd)        sum_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q  <= 1'b0;
      err_q <= '0;
      sum_q <= 1'b0;
    end else begin
      dr_q  <= dr_d;
      err_q <= err_d;
      sum_q <= sum_d;
    end
  end

  assign data_rdy = fifo_mode ? ~rx_fifo_empty : dr_q;
  assign err      = err_q;
  assign err_sum  = sum_q;
endmodule

// File: rtl/lsr_tx_track.sv
module lsr_tx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic tx_load,
  input  logic tx_write,
  input  logic tx_fifo_empty,
  input  logic tx_shift_idle,
  input  logic iir_rd,
  output logic thre,
  output logic temt,
  output logic irq
);
  logic thre_q, thre_d;
  logic irq_q, irq_d;

  always_comb begin
    thre_d = thre_q;
    if (fifo_mode)     thre_d = tx_fifo_empty & ~tx_write;
    else if (tx_write) thre_d = 1'b0;
    else if (tx_load)  thre_d = 1'b1;

    irq_d = irq_q;
    if (thre_d && !thre_q) irq_d = 1'b1;
    else if (iir_rd)       irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      thre_q <= thre_d;
      irq_q  <= irq_d;
    end
  end

  assign thre = thre_q;
  assign temt = thre_q & tx_shift_idle;
  assign irq  = irq_q;
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_lsr_pkg::*;
#(
  parameter int RX_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             rls_ie,
  input  logic             rx_done,
  input  logic             rx_par_bad,
  input  logic             rx_stop_bad,
  input  logic             rx_brk,
  input  logic             rx_pop,
  input  logic             rx_pop_err,
  input  logic             rx_fifo_full,
  input  logic             rx_fifo_empty,
  input  logic             rx_fifo_clr,
  input  logic             tx_load,
  input  logic             tx_write,
  input  logic             tx_fifo_empty,
  input  logic             tx_shift_idle,
  input  logic             lsr_rd,
  input  logic             iir_rd,
  output logic [LSR_W-1:0] lsr_q,
  output logic             irq_rls,
  output logic             irq_thre
);
  rx_err_t err;
  logic    data_rdy, err_sum, thre, temt;

  lsr_rx_track #(.RX_DEPTH(RX_DEPTH)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_mode     (fifo_mode),
    .rx_done       (rx_done),
    .rx_par_bad    (rx_par_bad),
    .rx_stop_bad   (rx_stop_bad),
    .rx_brk        (rx_brk),
    .rx_pop        (rx_pop),
    .rx_pop_err    (rx_pop_err),
    .rx_fifo_full  (rx_fifo_full),
    .rx_fifo_empty (rx_fifo_empty),
    .rx_fifo_clr   (rx_fifo_clr),
    .lsr_rd        (lsr_rd),
    .data_rdy      (data_rdy),
    .err           (err),
    .err_sum       (err_sum)
  );

  lsr_tx_track u_tx (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_mode     (fifo_mode),
    .tx_load       (tx_load),
    .tx_write      (tx_write),
    .tx_fifo_empty (tx_fifo_empty),
    .tx_shift_idle (tx_shift_idle),
    .iir_rd        (iir_rd),
    .thre          (thre),
    .temt          (temt),
    .irq           (irq_thre)
  );

  always_comb begin
    lsr_q          = '0;
    lsr_q[B_DRDY]  = data_rdy;
    lsr_q[B_OVR]   = err.ovr;
    lsr_q[B_PAR]   = err.par;
    lsr_q[B_FRM]   = err.frm;
    lsr_q[B_BRK]   = err.brk;
    lsr_q[B_THRE]  = thre;
    lsr_q[B_TEMT]  = temt;
    lsr_q[B_RXSUM] = err_sum;
  end

  assign irq_rls = rls_ie & (|err);
endmodule

// File: rtl/lsr_checks.sv
module lsr_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_mode,
  input logic       rx_done,
  input logic       rx_par_bad,
  input logic       lsr_rd,
  input logic       iir_rd,
  input logic       tx_write,
  input logic [7:0] lsr_q,
  input logic       irq_thre
);
  AST_PAR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_par_bad |=> lsr_q[2]); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !rx_done |=> lsr_q[4:2] == 3'b000); // R5
  AST_CHAR_NO_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !lsr_q[7]); // R7
  AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_write |=> !lsr_q[5]); // R9
  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_q[6] |-> lsr_q[5]); // R11
  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_thre) |-> $rose(lsr_q[5])); // R12
  AST_IIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rd |=> !irq_thre || $rose(lsr_q[5])); // R12
endmodule

bind uart_line_status lsr_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_mode  (fifo_mode),
  .rx_done    (rx_done),
  .rx_par_bad (rx_par_bad),
  .lsr_rd     (lsr_rd),
  .iir_rd     (iir_rd),
  .tx_write   (tx_write),
  .lsr_q      (lsr_q),
  .irq_thre   (irq_thre)
);

// File: tb/tb_uart_line_status.sv
`timescale 1ns/1ps
module tb_uart_line_status;
  logic clk = 1'b0;
  logic rst_n;
  logic fifo_mode, rls_ie, rx_done, rx_par_bad, rx_stop_bad, rx_brk;
  logic rx_pop, rx_pop_err, rx_fifo_full, rx_fifo_empty, rx_fifo_clr;
  logic tx_load, tx_write, tx_fifo_empty, tx_shift_idle, lsr_rd, iir_rd;
  logic [7:0] lsr_q;
  logic irq_rls, irq_thre;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [7:0] l;
    logic       r;
    logic       t;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  uart_line_status dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rls_ie(rls_ie),
    .rx_done(rx_done), .rx_par_bad(rx_par_bad), .rx_stop_bad(rx_stop_bad),
    .rx_brk(rx_brk), .rx_pop(rx_pop), .rx_pop_err(rx_pop_err),
    .rx_fifo_full(rx_fifo_full), .rx_fifo_empty(rx_fifo_empty),
    .rx_fifo_clr(rx_fifo_clr), .tx_load(tx_load), .tx_write(tx_write),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_idle(tx_shift_idle),
    .lsr_rd(lsr_rd), .iir_rd(iir_rd), .lsr_q(lsr_q), .irq_rls(irq_rls),
    .irq_thre(irq_thre)
  );

  task automatic compare(input exp_t e);
    total++;
    if (lsr_q !== e.l || irq_rls !== e.r || irq_thre !== e.t) begin
      bad++;
      $display("FAIL %s: got lsr=%02h rls=%0b thre=%0b, expected lsr=%02h rls=%0b thre=%0b",
               e.tag, lsr_q, irq_rls, irq_thre, e.l, e.r, e.t);
    end
  endtask

  // monitor: judges the state one step after each posedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  // driver: inputs already set at a negedge; queue expectation, run one cycle
  task automatic go(input logic [7:0] l, input logic r, input logic t, input string tag);
    exp_t e;
    e.l = l; e.r = r; e.t = t; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    rx_done = 0; rx_par_bad = 0; rx_stop_bad = 0; rx_brk = 0;
    rx_pop = 0; rx_pop_err = 0; rx_fifo_clr = 0;
    tx_load = 0; tx_write = 0; lsr_rd = 0; iir_rd = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got no end, expected end of run");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_t e;
    rst_n = 0; fifo_mode = 0; rls_ie = 0;
    rx_done = 0; rx_par_bad = 0; rx_stop_bad = 0; rx_brk = 0;
    rx_pop = 0; rx_pop_err = 0; rx_fifo_full = 0; rx_fifo_empty = 1; rx_fifo_clr = 0;
    tx_load = 0; tx_write = 0; tx_fifo_empty = 1; tx_shift_idle = 1;
    lsr_rd = 0; iir_rd = 0;
    repeat (3) @(negedge clk);
    e.l = 8'h60; e.r = 0; e.t = 0; e.tag = "R1 in reset";
    compare(e);
    rst_n = 1;
    go(8'h60, 0, 0, "R1 after reset");

    // character mode, transmit side
    tx_write = 1;                 go(8'h00, 0, 0, "R9 write clears");
    tx_load = 1;                  go(8'h60, 0, 1, "R12 load raises irq");
    go(8'h60, 0, 1, "R12 irq holds");
    iir_rd = 1;                   go(8'h60, 0, 0, "R12 iir clears");
    tx_shift_idle = 0;            go(8'h20, 0, 0, "R11 shifter busy");
    tx_shift_idle = 1;            go(8'h60, 0, 0, "R11 shifter idle");

    // character mode, receive side
    rx_done = 1;                  go(8'h61, 0, 0, "R2 data ready");
    rx_done = 1;                  go(8'h63, 0, 0, "R4 overrun char mode");
    rls_ie = 1;                   go(8'h63, 1, 0, "R6 enable raises irq");
    lsr_rd = 1;                   go(8'h61, 0, 0, "R5 read clears overrun");
    rx_pop = 1;                   go(8'h60, 0, 0, "R2 pop clears");
    rx_done = 1; rx_par_bad = 1;  go(8'h65, 1, 0, "R3 parity");
    rx_done = 1; rx_stop_bad = 1; rx_pop = 1; lsr_rd = 1;
                                  go(8'h69, 1, 0, "R5 set wins over read");
    lsr_rd = 1;                   go(8'h61, 0, 0, "R5 read clears framing");
    rx_done = 1; rx_brk = 1; rx_pop = 1;
                                  go(8'h71, 1, 0, "R3 break");
    lsr_rd = 1; rx_pop = 1;       go(8'h60, 0, 0, "R2 R5 read and pop");

    // FIFO mode, receive side
    fifo_mode = 1;                go(8'h60, 0, 0, "R10 enter FIFO mode");
    rx_done = 1; rx_par_bad = 1; rx_fifo_empty = 0;
                                  go(8'hE5, 1, 0, "R7 errored push");
    lsr_rd = 1;                   go(8'hE1, 0, 0, "R7 summary survives read");
    rx_pop = 1; rx_pop_err = 1; rx_fifo_empty = 1;
                                  go(8'hE0, 0, 0, "R8 pop decrements");
    lsr_rd = 1;                   go(8'h60, 0, 0, "R7 read clears summary");
    rx_done = 1; rx_fifo_full = 1; rx_fifo_empty = 0;
                                  go(8'h63, 1, 0, "R4 overrun FIFO mode");
    lsr_rd = 1; rx_fifo_full = 0; rx_fifo_empty = 1;
                                  go(8'h60, 0, 0, "R4 overrun not counted");

    // FIFO mode, transmit side
    tx_write = 1; tx_fifo_empty = 0; go(8'h00, 0, 0, "R10 write clears");
    tx_fifo_empty = 1;            go(8'h60, 0, 1, "R10 empty sets");
    tx_write = 1; tx_fifo_empty = 0; go(8'h00, 0, 1, "R12 irq held");
    iir_rd = 1; tx_fifo_empty = 1; go(8'h60, 0, 1, "R12 rise wins over iir");
    iir_rd = 1;                   go(8'h60, 0, 0, "R12 iir clears");

    // counter clears
    rx_done = 1; rx_par_bad = 1; rx_fifo_empty = 0;
                                  go(8'hE5, 1, 0, "R7 second errored push");
    rx_fifo_clr = 1; rx_fifo_empty = 1; lsr_rd = 1;
                                  go(8'h60, 0, 0, "R8 FIFO reset clears");
    rx_done = 1; rx_brk = 1; rx_fifo_empty = 0;
                                  go(8'hF1, 1, 0, "R3 break FIFO mode");
    fifo_mode = 0; rx_fifo_empty = 1;
                                  go(8'h70, 1, 0, "R8 mode off clears");
    lsr_rd = 1;                   go(8'h60, 0, 0, "R5 final read");
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule